// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block translates a 32-bit effective address into a physical page number by walking a hashed page table kept in ordinary memory. The top four address bits pick one of sixteen segment words; the segment word supplies a 24-bit virtual segment identifier and the protection-key selectors. From the identifier and the 16-bit page index the engine derives a group address and a compare tag. It then reads the eight two-word entries of the primary group one word at a time. If no entry of that group matches, it repeats the scan over the secondary group.

When an entry matches, the engine applies the page-protection rules for the current key. On an allowed access it marks the entry referenced, and also changed for a store, writing the second word back only when a bit actually changes. Segments flagged as direct-store, and instruction fetches from no-execute segments, are answered at once without touching memory.

A request is accepted while `busy` is low. The result appears with a one-cycle `done` pulse and stays on the result ports until the next request completes.

Top module: `hpt_walker`

## Requirements
- R1: The segment word is chosen by `req_ea[31:28]`. The protection key is 1 when segment bit 29 is set and `req_user` is 1, or when segment bit 30 is set and `req_user` is 0. Otherwise the key is 0.
- R2: With vsid = segment[23:0] and pidx = `req_ea[27:12]`, the primary hash is h = ((vsid ^ pidx) & 0x7FFFF) << 6. The group address is (cfg & 0xFFFF0000) | (h & (((cfg & 0x1FF) << 16) | 0xFFC0)). Entry k of a group sits at group + 8k (first word) and group + 8k + 4 (second word). An entry matches when its first word has bit 31 set, bit 6 equal to the pass number (0 primary, 1 secondary), and first word & 0x7FFFFFBF equal to (vsid << 7) | (pidx >> 10).
- R3: The secondary pass uses the hash (~h) & 0x01FFFFC0 under the same mask. It runs only when no entry of the primary group matched; a primary match that is refused is not retried in the secondary group.
- R4: Status MISS is reported only after all eight entries of both groups have been scanned without a match.
- R5: With key 0, the page-protection field PP = second word bits [1:0] always permits reads, and permits writes unless PP = 3.
- R6: With key 1, PP = 0 permits nothing, PP = 1 or 3 permits reads only, and PP = 2 permits reads and writes.
- R7: An access the rules refuse gives status PROT. Every non-HIT result drives both permission outputs to 0.
- R8: On a HIT the engine sets bit 8 (referenced) of the second word, and also bit 7 (changed) for a write. It writes the word back to group + 8k + 4 only if one of these bits was clear.
- R9: On a read HIT whose changed bit was clear before the access, `res_wr_ok` is 0 even when the rules permit writes.
- R10: When several entries match, the first one in scan order is used. If their second words differ under the mask 0xFFFFF07B, the status is CONFLICT and nothing is written back.
- R11: An instruction fetch (`req_fetch` = 1) to a segment with bit 28 set returns status NOEXEC one cycle after acceptance, with no memory access. Data accesses to such a segment are walked normally.
- R12: A segment with bit 31 set returns status DIRECT one cycle after acceptance, with no memory access. This check takes priority over R11.
- R13: The status codes are HIT = 0, MISS = 1, PROT = 2, NOEXEC = 3, DIRECT = 4 and CONFLICT = 5. On a HIT, `res_ppn` equals second word bits [31:12]. `done` is high for exactly one cycle. After reset the status is MISS, the page number is 0 and both permissions are 0.
- R14: Read data is taken from `mem_rdata` one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken while busy is low) |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| seg_regs | input | 512 | Sixteen segment words, word i at bits [32i+31:32i] |
| table_cfg | input | 32 | Table origin (bits 31:16) and hash mask (bits 8:0) |
| busy | output | 1 | A translation is in progress |
| mem_rd | output | 1 | Table word read request |
| mem_wr | output | 1 | Table word write request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| done | output | 1 | One-cycle result strobe |
| res_status | output | 3 | Result code (see R13) |
| res_ppn | output | 20 | Physical page number |
| res_rd_ok | output | 1 | Read permitted |
| res_wr_ok | output | 1 | Write permitted |

## Verification
The embedded properties watch, on every cycle, that reads and writes never share a cycle, and that each writeback targets a second word and carries the referenced bit. They also check that every table read stays inside the configured table region, that direct-store and no-execute requests finish in the next cycle, that non-HIT results carry no permissions, and that `done` never lasts two cycles. Only the bench scenarios can show that the hash, the tag and the pass bit select the right entry. The same holds for the protection matrix per key and PP, the secondary pass, miss detection, duplicate handling and the exact word left in memory after each walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam logic [31:0] REF_BIT    = 32'h0000_0100;
  localparam logic [31:0] CHG_BIT    = 32'h0000_0080;
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;
  localparam logic [31:0] TAG_MASK   = 32'h7FFF_FFBF;

  typedef enum logic [2:0] {
    ST_HIT      = 3'd0,
    ST_MISS     = 3'd1,
    ST_PROT     = 3'd2,
    ST_NOEXEC   = 3'd3,
    ST_DIRECT   = 3'd4,
    ST_CONFLICT = 3'd5
  } walk_status_e;

  function automatic logic prot_key(input logic [31:0] seg, input logic user);
    return (seg[29] && user) || (seg[30] && !user);
  endfunction

  function automatic logic [31:0] primary_hash(input logic [23:0] vsid, input logic [15:0] pidx);
    logic [31:0] mix;
    mix = {8'h00, vsid ^ {8'h00, pidx}};
    return (mix & 32'h0007_FFFF) << 6;
  endfunction

  function automatic logic [31:0] secondary_hash(input logic [31:0] h);
    return ~h & 32'h01FF_FFC0;
  endfunction

  function automatic logic [31:0] group_addr(input logic [31:0] cfg, input logic [31:0] h);
    logic [31:0] mask;
    mask = {7'd0, cfg[8:0], 16'hFFC0};
    return {cfg[31:16], 16'h0000} | (h & mask);
  endfunction

  function automatic logic [31:0] compare_tag(input logic [23:0] vsid, input logic [15:0] pidx);
    return {1'b0, vsid, 1'b0, pidx[15:10]};
  endfunction

  function automatic logic entry_hit(input logic [31:0] w0, input logic [31:0] tag, input logic pass);
    return w0[31] && (w0[6] == pass) && ((w0 & TAG_MASK) == tag);
  endfunction

  // returns {read_allowed, write_allowed}
  function automatic logic [1:0] pp_rights(input logic [1:0] pp, input logic key);
    if (!key) return {1'b1, pp != 2'd3};
    case (pp)
      2'd0:    return 2'b00;
      2'd2:    return 2'b11;
      default: return 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen import hpt_pkg::*; (
  input  logic [31:0] seg_word,
  input  logic [15:0] pidx,
  input  logic [31:0] cfg,
  input  logic        user,
  output logic        key,
  output logic [31:0] grp_pri,
  output logic [31:0] grp_sec,
  output logic [31:0] tag
);
  logic [31:0] h_pri;

  always_comb begin
    key     = prot_key(seg_word, user);
    h_pri   = primary_hash(seg_word[23:0], pidx);
    grp_pri = group_addr(cfg, h_pri);
    grp_sec = group_addr(cfg, secondary_hash(h_pri));
    tag     = compare_tag(seg_word[23:0], pidx);
  end
endmodule

// File: rtl/hpt_rights.sv
module hpt_rights import hpt_pkg::*; (
  input  logic [31:0] word1,
  input  logic        key,
  input  logic        is_write,
  output logic        rd_ok,
  output logic        wr_ok,
  output logic        fault,
  output logic [31:0] new_word1,
  output logic        need_wb
);
  logic [1:0] rights;

  always_comb begin
    rights    = pp_rights(word1[1:0], key);
    fault     = is_write ? !rights[0] : !rights[1];
    rd_ok     = rights[1];
    wr_ok     = rights[0] && (is_write || word1[7]);
    new_word1 = word1 | REF_BIT | (is_write ? CHG_BIT : 32'd0);
    need_wb   = (new_word1 != word1);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker import hpt_pkg::*; #(
  parameter int unsigned NUM_SEGS      = 16,
  parameter int unsigned GROUP_ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_ea,
  input  logic                  req_write,
  input  logic                  req_fetch,
  input  logic                  req_user,
  input  logic [NUM_SEGS*32-1:0] seg_regs,
  input  logic [31:0]           table_cfg,
  output logic                  busy,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  output logic                  done,
  output logic [2:0]            res_status,
  output logic [19:0]           res_ppn,
  output logic                  res_rd_ok,
  output logic                  res_wr_ok
);
  localparam int unsigned SEG_SEL_W = $clog2(NUM_SEGS);
  localparam int unsigned IDX_W     = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_EVAL, S_DECIDE, S_WB, S_DONE} walk_state_e;

  walk_state_e  state;
  logic [31:0]  seg_arr [NUM_SEGS];
  logic [31:0]  sel_seg;
  logic [15:0]  q_pidx;
  logic [31:0]  q_seg, q_cfg, q_keep;
  logic         q_write, q_user, q_pass, q_w0_hit, q_found, q_conflict;
  logic [IDX_W-1:0] q_idx, q_kidx;
  walk_status_e r_status;
  logic [19:0]  r_ppn;
  logic         r_rd, r_wr;
  logic         unused_ea;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    assign seg_arr[g] = seg_regs[g*32 +: 32];
  end
  assign sel_seg   = seg_arr[req_ea[31 -: SEG_SEL_W]];
  assign unused_ea = ^req_ea[11:0];

  // named events for the assertions
  logic accept, go_direct, go_noexec, w0_hit, w1_agree, last_slot;
  logic key, a_fault, a_rd_ok, a_wr_ok, a_need_wb;
  logic [31:0] grp_pri, grp_sec, tag, cur_grp, slot_addr, new_word1;

  assign accept    = req_valid && (state == S_IDLE);
  assign go_direct = sel_seg[31];
  assign go_noexec = req_fetch && sel_seg[28];
  assign last_slot = (q_idx == LAST_IDX);

  hpt_addr_gen u_addr (
    .seg_word(q_seg), .pidx(q_pidx), .cfg(q_cfg), .user(q_user),
    .key(key), .grp_pri(grp_pri), .grp_sec(grp_sec), .tag(tag)
  );

  hpt_rights u_rights (
    .word1(q_keep), .key(key), .is_write(q_write),
    .rd_ok(a_rd_ok), .wr_ok(a_wr_ok), .fault(a_fault),
    .new_word1(new_word1), .need_wb(a_need_wb)
  );

  assign cur_grp   = q_pass ? grp_sec : grp_pri;
  assign slot_addr = cur_grp + 32'({q_idx, 3'b000});
  assign w0_hit    = entry_hit(mem_rdata, tag, q_pass);
  assign w1_agree  = ((q_keep ^ mem_rdata) & AGREE_MASK) == 32'd0;

  always_comb begin
    mem_rd    = (state == S_RD0) || (state == S_RD1);
    mem_wr    = (state == S_WB);
    mem_wdata = new_word1;
    case (state)
      S_RD1:   mem_addr = slot_addr | 32'd4;
      S_WB:    mem_addr = (cur_grp + 32'({q_kidx, 3'b000})) | 32'd4;
      default: mem_addr = slot_addr;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign res_status = r_status;
  assign res_ppn    = r_ppn;
  assign res_rd_ok  = r_rd;
  assign res_wr_ok  = r_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q_pidx <= '0; q_seg <= '0; q_cfg <= '0; q_keep <= '0;
      q_write <= 1'b0; q_user <= 1'b0; q_pass <= 1'b0; q_w0_hit <= 1'b0;
      q_found <= 1'b0; q_conflict <= 1'b0; q_idx <= '0; q_kidx <= '0;
      r_status <= ST_MISS; r_ppn <= '0; r_rd <= 1'b0; r_wr <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          q_pidx <= req_ea[27:12]; q_seg <= sel_seg; q_cfg <= table_cfg;
          q_write <= req_write; q_user <= req_user;
          q_pass <= 1'b0; q_idx <= '0; q_found <= 1'b0; q_conflict <= 1'b0;
          if (go_direct || go_noexec) begin
            r_status <= go_direct ? ST_DIRECT : ST_NOEXEC;
            r_ppn <= '0; r_rd <= 1'b0; r_wr <= 1'b0;
            state <= S_DONE;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: state <= S_RD1;
        S_RD1: begin
          q_w0_hit <= w0_hit;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (q_w0_hit) begin
            if (!q_found) begin
              q_found <= 1'b1; q_keep <= mem_rdata; q_kidx <= q_idx;
            end else if (!w1_agree) begin
              q_conflict <= 1'b1;
            end
          end
          if (last_slot) state <= S_DECIDE;
          else begin
            q_idx <= q_idx + IDX_W'(1);
            state <= S_RD0;
          end
        end
        S_DECIDE: begin
          r_ppn <= '0; r_rd <= 1'b0; r_wr <= 1'b0;
          if (!q_found && !q_pass) begin
            q_pass <= 1'b1; q_idx <= '0;
            state <= S_RD0;
          end else if (!q_found) begin
            r_status <= ST_MISS; state <= S_DONE;
          end else if (q_conflict) begin
            r_status <= ST_CONFLICT; state <= S_DONE;
          end else if (a_fault) begin
            r_status <= ST_PROT; state <= S_DONE;
          end else begin
            r_status <= ST_HIT; r_ppn <= q_keep[31:12];
            r_rd <= a_rd_ok; r_wr <= a_wr_ok;
            state <= a_need_wb ? S_WB : S_DONE;
          end
        end
        S_WB:   state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r14_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r8_wb_marks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[8] && mem_addr[2:0] == 3'b100));

  a_r2_reads_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[31:25] == q_cfg[31:25]));

  a_r12_direct_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go_direct) |=> (done && res_status == ST_DIRECT && !mem_rd));

  a_r11_noexec_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_direct && go_noexec) |=> (done && res_status == ST_NOEXEC && !mem_rd));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_no_perm_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_status != ST_HIT) |-> (!res_rd_ok && !res_wr_ok));

  a_r9_clean_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECIDE && q_found && !q_conflict && !a_fault && !q_write && !q_keep[7])
      |=> !res_wr_ok);
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  localparam logic [31:0] CFG = 32'h0001_0000;
  localparam logic [31:0] EA  = 32'h3ABC_D123;
  localparam int NV = 16;
  localparam logic [31:0] V_SEG [NV] = '{32'h00012345, 32'h00012345, 32'h00012345, 32'h00012345,
                                         32'h20012345, 32'h20012345, 32'h20012345, 32'h20012345,
                                         32'h00012345, 32'h00012345, 32'h00012345, 32'h10012345,
                                         32'h90012345, 32'h40012345, 32'h40012345, 32'h10012345};
  localparam int V_SLOT [NV]  = '{0,3,1,1,2,5,6,4,7,8,2,0,0,0,0,0};
  localparam int V_WHERE [NV] = '{0,0,0,0,0,0,0,0,1,0,2,0,0,0,0,0}; // 0 pri, 1 sec, 2 pri w/ wrong pass bit
  localparam logic [1:0] V_PP [NV] = '{2,2,3,3,0,1,2,3,2,2,2,2,2,0,0,2};
  localparam logic [1:0] V_RC [NV] = '{0,0,3,3,3,3,2,3,3,3,3,3,3,3,3,3}; // {ref,chg}
  localparam logic V_WR [NV] = '{0,1,1,0,0,0,1,1,0,0,0,0,0,0,0,0};
  localparam logic V_FE [NV] = '{0,0,0,0,0,0,0,0,0,0,0,1,1,0,0,0};
  localparam logic V_US [NV] = '{0,0,0,0,1,1,1,1,0,0,0,0,0,0,1,0};
  localparam logic [2:0] V_ST [NV] = '{0,0,2,0,2,0,0,2,0,1,1,3,4,2,0,0};
  localparam logic V_R [NV] = '{1,1,0,1,0,1,1,0,1,0,0,0,0,0,1,1};
  localparam logic V_W [NV] = '{0,1,0,0,0,0,1,0,1,0,0,0,0,0,1,1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [511:0] seg_regs = '0;
  logic busy, mem_rd, mem_wr, done, res_rd_ok, res_wr_ok;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0] res_status;
  logic [19:0] res_ppn;
  logic [31:0] mem [16384];
  logic tb_we = 1'b0;
  logic [31:0] tb_a = '0, tb_d = '0;
  int n_chk = 0, n_bad = 0, overlap = 0;
  string v_tag [NV];

  always #5 clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea), .req_write(req_write),
    .req_fetch(req_fetch), .req_user(req_user), .seg_regs(seg_regs), .table_cfg(CFG),
    .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .res_status(res_status), .res_ppn(res_ppn),
    .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[15:2]];
    if (mem_wr) mem[mem_addr[15:2]] <= mem_wdata;
    if (tb_we)  mem[tb_a[15:2]] <= tb_d;
  end
  always @(negedge clk) if (mem_rd && mem_wr) overlap++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [31:0] grp_of(input logic [31:0] seg, input bit sec);
    logic [31:0] v, p, h;
    v = seg & 32'h00FF_FFFF;
    p = (EA >> 12) & 32'h0000_FFFF;
    h = ((v ^ p) % 32'h0008_0000) * 64;
    if (sec) h = (h ^ 32'hFFFF_FFFF) & 32'h01FF_FFC0;
    return (CFG & 32'hFFFF_0000) | (h & (((CFG & 32'h1FF) << 16) | 32'hFFC0));
  endfunction

  function automatic logic [31:0] w0_of(input logic [31:0] seg, input bit hbit);
    return 32'h8000_0000 | ((seg & 32'h00FF_FFFF) << 7) | (((EA >> 12) & 32'hFFFF) >> 10)
           | (hbit ? 32'h40 : 32'h0);
  endfunction

  function automatic logic [31:0] w1_of(input logic [19:0] rpn, input logic [1:0] rc, input logic [1:0] pp);
    return {rpn, 12'h0} | (rc[1] ? 32'h100 : 32'h0) | (rc[0] ? 32'h80 : 32'h0) | 32'h18 | 32'(pp);
  endfunction

  task automatic clear_groups(input logic [31:0] seg);
    for (int i = 0; i < 16; i++) begin
      poke(grp_of(seg, 1'b0) + 32'(i * 4), 32'h0);
      poke(grp_of(seg, 1'b1) + 32'(i * 4), 32'h0);
    end
  endtask

  task automatic walk(input logic wr, input logic fe, input logic us);
    int guard;
    req_ea = EA; req_write = wr; req_fetch = fe; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] g, w1, exp1;
    v_tag = '{"R9", "R8", "R5", "R5", "R6", "R6", "R6", "R6", "R3", "R4", "R2", "R11",
              "R12", "R1", "R1", "R11"};
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset status", 32'(res_status), 32'd1);
    chk("R13 reset perms", {30'd0, res_rd_ok, res_wr_ok}, 32'd0);
    chk("R13 reset done/busy", {30'd0, done, busy}, 32'd0);
    chk("R14 reset port idle", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      seg_regs[3*32 +: 32] = V_SEG[v];
      clear_groups(V_SEG[v]);
      g = grp_of(V_SEG[v], V_WHERE[v] == 1);
      w1 = w1_of(20'hA5000 + 20'(v), V_RC[v], V_PP[v]);
      if (V_SLOT[v] < 8) begin
        poke(g + 32'(V_SLOT[v] * 8), w0_of(V_SEG[v], V_WHERE[v] != 0));
        poke(g + 32'(V_SLOT[v] * 8 + 4), w1);
      end
      walk(V_WR[v], V_FE[v], V_US[v]);
      chk({v_tag[v], " status"}, 32'(res_status), 32'(V_ST[v]));
      chk({v_tag[v], " read perm"}, 32'(res_rd_ok), 32'(V_R[v]));
      chk({v_tag[v], " write perm"}, 32'(res_wr_ok), 32'(V_W[v]));
      if (V_ST[v] == 3'd0) chk("R13 ppn", 32'(res_ppn), 32'h000A_5000 + 32'(v));
      @(negedge clk);
      if (V_SLOT[v] < 8) begin
        exp1 = (V_ST[v] == 3'd0) ? (w1 | 32'h100 | (V_WR[v] ? 32'h80 : 32'h0)) : w1;
        chk({v_tag[v], " R8 word after walk"}, mem[(g + 32'(V_SLOT[v] * 8 + 4)) >> 2 & 32'h3FFF], exp1);
      end
    end

    // R10 conflicting duplicates
    seg_regs[3*32 +: 32] = 32'h00012345;
    clear_groups(32'h00012345);
    g = grp_of(32'h00012345, 1'b0);
    poke(g + 8, w0_of(32'h00012345, 1'b0));  poke(g + 12, w1_of(20'h11111, 2'd0, 2'd2));
    poke(g + 32, w0_of(32'h00012345, 1'b0)); poke(g + 36, w1_of(20'h22222, 2'd0, 2'd2));
    walk(1'b0, 1'b0, 1'b0);
    chk("R10 conflict status", 32'(res_status), 32'd5);
    @(negedge clk);
    chk("R10 conflict no writeback", mem[((g + 12) >> 2) & 32'h3FFF], w1_of(20'h11111, 2'd0, 2'd2));

    // R10 agreeing duplicates differing only in ref/chg: first one used
    clear_groups(32'h00012345);
    poke(g + 16, w0_of(32'h00012345, 1'b0)); poke(g + 20, w1_of(20'h33333, 2'd0, 2'd2));
    poke(g + 40, w0_of(32'h00012345, 1'b0)); poke(g + 44, w1_of(20'h33333, 2'd3, 2'd2));
    walk(1'b0, 1'b0, 1'b0);
    chk("R10 duplicate status", 32'(res_status), 32'd0);
    chk("R10 duplicate first used (R9 no write)", 32'(res_wr_ok), 32'd0);
    chk("R10 duplicate ppn", 32'(res_ppn), 32'h33333);
    @(negedge clk);
    chk("R10 first slot updated", mem[((g + 20) >> 2) & 32'h3FFF], w1_of(20'h33333, 2'd2, 2'd2));
    chk("R10 second slot untouched", mem[((g + 44) >> 2) & 32'h3FFF], w1_of(20'h33333, 2'd3, 2'd2));

    // R3 refused primary match is not retried in the secondary group
    seg_regs[3*32 +: 32] = 32'h20012345;
    clear_groups(32'h20012345);
    g = grp_of(32'h20012345, 1'b0);
    poke(g, w0_of(32'h20012345, 1'b0)); poke(g + 4, w1_of(20'h44444, 2'd3, 2'd0));
    g = grp_of(32'h20012345, 1'b1);
    poke(g, w0_of(32'h20012345, 1'b1)); poke(g + 4, w1_of(20'h55555, 2'd0, 2'd2));
    walk(1'b0, 1'b0, 1'b1);
    chk("R3 primary refusal final", 32'(res_status), 32'd2);
    @(negedge clk);
    chk("R3 secondary untouched", mem[((g + 4) >> 2) & 32'h3FFF], w1_of(20'h55555, 2'd0, 2'd2));

    chk("R14 no read/write overlap", 32'(overlap), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule